// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Generator

This block drives a small bank of pulse-width outputs that all run on one common period. A single clock divider turns the system clock into a slower local tick, and a shared 8-bit period counter steps once per local tick, so every period lasts exactly 256 local ticks. The only way to stretch or shrink the period is to change the divider setting. Each channel compares its own 8-bit duty value against the shared counter, and its output is high from the start of each period until the counter passes that value.

Software programs the bank through a simple word-addressed register port. Each channel has a duty register. One control register holds the divider setting and a single enable that starts or stops every channel at once. A duty value of N gives a pulse of N+1 local ticks, so the shortest pulse is one tick and the longest fills the whole period. An active output therefore never stays low for a full period. A new duty value is held back until the next period boundary, so a write never cuts a pulse short partway through.

Top module: `pwm_bank`

## Requirements
- R1: The period is always 256 local ticks, and one local tick lasts prescale+1 clock cycles, where prescale is the 8-bit divider setting.
- R2: The control register is at byte offset 0x50. The divider setting is split across it: prescale bits 3:0 sit in control bits 3:0 and prescale bits 7:4 sit in control bits 14:11.
- R3: With duty value N, a channel is high for the first N+1 local ticks of each period and low for the rest. N=0 gives exactly one tick high.
- R4: A duty value of 255 keeps the channel high for all 256 ticks, so the output never drops while enabled.
- R5: The duty register of channel x is at byte offset 4*x and uses data bits 7:0. Address bits 1:0 are ignored.
- R6: Control bit 9 is the common enable. While it is 0, every output is low and the divider and period counter are held at zero. After a write sets it, the next clock cycle is the first cycle of local tick 0.
- R7: A duty write takes effect only at the start of the next period. The period in progress keeps the old duty value.
- R8: Reads return the stored field values, with unused bits at zero. Unmapped offsets read as zero, and a write to an unmapped offset changes nothing.
- R9: All channels share one counter, so their periods start on the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH | One pulse output per channel |

## Verification
A fault in the divider or the period counter changes the number of high cycles counted over one period window, and it does so in the first period after enable. A misaligned counter shows up on the first sample after the enable write, because a duty-0 channel must be high in that cycle and low in the next. A shadow duty register that loads at the wrong time changes the high count of the period in which the write lands, so that error shows within one period. A decode fault shows up at once on the next read, or on the output when a stray write reaches a duty or enable field.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 8;
    localparam int PS_W      = 8;
    localparam int CTRL_OFF  = 'h50;
    localparam int EN_BIT    = 9;
    localparam int PS_LO_POS = 0;
    localparam int PS_HI_POS = 11;

    typedef struct packed {
        logic            en;
        logic [PS_W-1:0] prescale;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_to_word(ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PS_LO_POS +: 4] = c.prescale[3:0];
        w[PS_HI_POS +: 4] = c.prescale[7:4];
        w[EN_BIT]         = c.en;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(logic [DATA_W-1:0] w);
        ctrl_t c;
        c.prescale = {w[PS_HI_POS +: 4], w[PS_LO_POS +: 4]};
        c.en       = w[EN_BIT];
        return c;
    endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic [NUM_CH-1:0][CNT_W-1:0] duty_o,
    output ctrl_t                        ctrl_o
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(CTRL_OFF / 4);

    logic [IDX_W-1:0] widx;
    ctrl_t            ctrl_q;

    assign widx = bus_addr[ADDR_W-1:2];

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (bus_we && widx == CTRL_IDX)
            ctrl_q <= word_to_ctrl(bus_wdata);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_duty
        always_ff @(posedge clk) begin
            if (rst)
                duty_o[c] <= '0;
            else if (bus_we && widx == IDX_W'(c))
                duty_o[c] <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (widx == CTRL_IDX)
            bus_rdata = ctrl_to_word(ctrl_q);
        for (int c = 0; c < NUM_CH; c++)
            if (widx == IDX_W'(c))
                bus_rdata = {{(DATA_W-CNT_W){1'b0}}, duty_o[c]};
    end

    assign ctrl_o = ctrl_q;

    // R2 / R6: a control write lands the enable bit in the next cycle
    p_ctrl_write_r6: assert property (@(posedge clk) disable iff (rst)
        bus_we && widx == CTRL_IDX |=> ctrl_q.en == $past(bus_wdata[EN_BIT]));
    // R8: any write outside the map leaves the control fields unchanged
    p_unmapped_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        bus_we && widx != CTRL_IDX && widx >= IDX_W'(NUM_CH) |=> $stable(ctrl_q));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [PS_W-1:0] prescale,
    output logic [CNT_W-1:0] pcnt,
    output logic            reload
);
    localparam logic [CNT_W-1:0] LAST = '1;

    logic [PS_W-1:0] div_cnt;
    logic            tick;

    assign tick   = en && (div_cnt >= prescale);
    assign reload = !en || (tick && pcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_cnt <= '0;
            pcnt    <= '0;
        end else begin
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
            if (tick)
                pcnt <= pcnt + 1'b1;
        end
    end

    // R1: the shared counter wraps to zero after step 255
    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        en && tick && pcnt == LAST |=> pcnt == '0);
    // R1: the counter moves only on a local tick
    p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (rst)
        en && !tick |=> $stable(pcnt) || !$past(en));
    // R6: disabled means the counter sits at zero
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> pcnt == '0);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             reload,
    input  logic [CNT_W-1:0] duty,
    input  logic [CNT_W-1:0] pcnt,
    output logic             pwm_o
);
    logic [CNT_W-1:0] shadow;

    always_ff @(posedge clk) begin
        if (rst)
            shadow <= '0;
        else if (reload)
            shadow <= duty;
    end

    assign pwm_o = en && (pcnt <= shadow);

    // R6: no pulse while the bank is disabled
    p_low_when_off_r6: assert property (@(posedge clk) disable iff (rst)
        !en |-> !pwm_o);
    // R3: the first tick of every period is always high
    p_first_tick_high_r3: assert property (@(posedge clk) disable iff (rst)
        en && pcnt == '0 |-> pwm_o);
    // R7: the active duty value stays put inside a period
    p_duty_held_r7: assert property (@(posedge clk) disable iff (rst)
        en && !reload |=> $stable(shadow));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [NUM_CH-1:0][CNT_W-1:0] duty;
    ctrl_t                        ctrl;
    logic [CNT_W-1:0]             pcnt;
    logic                         reload;

    pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .duty_o    (duty),
        .ctrl_o    (ctrl)
    );

    pwm_timebase u_tb (
        .clk      (clk),
        .rst      (rst),
        .en       (ctrl.en),
        .prescale (ctrl.prescale),
        .pcnt     (pcnt),
        .reload   (reload)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_channel u_ch (
            .clk    (clk),
            .rst    (rst),
            .en     (ctrl.en),
            .reload (reload),
            .duty   (duty[c]),
            .pcnt   (pcnt),
            .pwm_o  (pwm_out[c])
        );
    end

    // R9: every output is high on the first tick of a shared period
    p_aligned_start_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl.en && pcnt == '0 |-> pwm_out == '1);
endmodule

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    typedef struct {
        int    ch;
        int    exp;
        string tag;
    } exp_t;

    logic            clk = 0;
    logic            rst = 1;
    logic            bus_we = 0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  pwm_out;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t sb[$];
    int   cnt[NCH];

    pwm_bank #(.NUM_CH(NCH), .ADDR_W(8)) dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ctrl_word(bit en, logic [7:0] ps);
        return ({17'd0, ps[7:4], 11'd0} | {22'd0, en, 9'd0} | {28'd0, ps[3:0]});
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 0;
    endtask

    task automatic rd_check(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        #1 check(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    task automatic push_exp(int e0, int e1, int e2, int e3, string tag);
        int e[NCH];
        e = '{e0, e1, e2, e3};
        for (int c = 0; c < NCH; c++) sb.push_back('{c, e[c], tag});
    endtask

    // monitor: counts high cycles over a window, optionally issues one write
    // mid-window, then pops expected items and compares
    task automatic measure(int n, bit score, int mid, logic [7:0] ma, logic [31:0] md);
        for (int c = 0; c < NCH; c++) cnt[c] = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_we = 0;
            for (int c = 0; c < NCH; c++) if (pwm_out[c] === 1'b1) cnt[c]++;
            if (i == mid) begin
                bus_we = 1; bus_addr = ma; bus_wdata = md;
            end
        end
        if (mid >= n - 1) begin
            @(posedge clk);
            #1 bus_we = 0;
        end
        if (score) begin
            for (int c = 0; c < NCH; c++) begin
                exp_t x;
                x = sb.pop_front();
                check(cnt[x.ch] == x.exp, $sformatf("%s ch%0d", x.tag, x.ch),
                      cnt[x.ch], x.exp);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // reset state (R6, R8)
        @(negedge clk);
        check(pwm_out === '0, "R6 reset outputs low", pwm_out, 0);
        rd_check(8'h50, 32'h0, "R8 reset ctrl");
        rd_check(8'h00, 32'h0, "R5 reset duty0");

        // register map (R5, R2, R8)
        wr(8'h08, 32'hFFFF_FF5A);
        rd_check(8'h08, 32'h5A, "R5 duty2 readback");
        rd_check(8'h0B, 32'h5A, "R5 low address bits ignored");
        wr(8'h50, 32'hFFFF_FFFF);
        rd_check(8'h50, 32'h0000_7A0F, "R2 ctrl field placement");
        wr(8'h50, 32'h0);
        rd_check(8'h44, 32'h0, "R8 unmapped reads zero");
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        rd_check(8'h50, 32'h0, "R8 unmapped write leaves ctrl");
        rd_check(8'h08, 32'h5A, "R8 unmapped write leaves duty2");
        rd_check(8'h00, 32'h0, "R8 unmapped write leaves duty0");

        // duties 0,1,128,255 while disabled: all low (R6)
        wr(8'h00, 32'd0); wr(8'h04, 32'd1); wr(8'h08, 32'd128); wr(8'h0C, 32'd255);
        push_exp(0, 0, 0, 0, "R6 disabled outputs low");
        measure(300, 1, -1, 8'h0, 32'h0);

        // prescale 0: one period of 256 cycles (R1, R3, R4, R9)
        wr(8'h50, ctrl_word(1, 8'h00));
        push_exp(1, 2, 129, 256, "R3/R4 high ticks, prescale 0");
        measure(256, 1, -1, 8'h0, 32'h0);
        push_exp(1, 2, 129, 256, "R1 second period repeats");
        measure(256, 1, -1, 8'h0, 32'h0);

        // disable mid-run, then restart from tick 0 (R6)
        measure(77, 0, -1, 8'h0, 32'h0);
        wr(8'h50, ctrl_word(0, 8'h00));
        push_exp(0, 0, 0, 0, "R6 disable forces low");
        measure(5, 1, -1, 8'h0, 32'h0);
        wr(8'h50, ctrl_word(1, 8'h00));
        push_exp(1, 1, 1, 1, "R6 restart at tick 0 R9");
        measure(1, 1, -1, 8'h0, 32'h0);
        push_exp(0, 1, 128, 255, "R6 rest of restarted period");
        measure(255, 1, -1, 8'h0, 32'h0);

        // prescale 2 in the low nibble (R1, R2)
        wr(8'h50, ctrl_word(0, 8'h00));
        wr(8'h50, ctrl_word(1, 8'h02));
        push_exp(3, 6, 387, 768, "R1 prescale 2");
        measure(768, 1, -1, 8'h0, 32'h0);

        // prescale 0x12 uses both nibbles (R2)
        wr(8'h50, ctrl_word(0, 8'h00));
        wr(8'h00, 32'd3); wr(8'h04, 32'd0); wr(8'h08, 32'd255); wr(8'h0C, 32'd127);
        wr(8'h50, ctrl_word(1, 8'h12));
        push_exp(76, 19, 4864, 2432, "R2 split prescale 0x12");
        measure(4864, 1, -1, 8'h0, 32'h0);

        // duty change mid-period waits for next period (R7)
        wr(8'h50, ctrl_word(0, 8'h00));
        wr(8'h00, 32'd200); wr(8'h04, 32'd5); wr(8'h08, 32'd60); wr(8'h0C, 32'd0);
        wr(8'h50, ctrl_word(1, 8'h00));
        push_exp(201, 6, 61, 1, "R7 old duty kept in current period");
        measure(256, 1, 50, 8'h00, 32'd10);
        push_exp(11, 6, 61, 1, "R7 new duty from next period");
        measure(256, 1, -1, 8'h0, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule